// File: doc/BRIEF.md
# Transactional Conflict Detector

This block watches the memory traffic of a small multicore (up to 16 cores) that runs hardware transactions. For each core it keeps a record of the cache lines that the core's current transaction has read and written. Every access on the shared access port is compared against the records of all other cores that have an open transaction. A conflict is reported combinationally, in the same cycle as the access. The report names the requesting core and gives a bitmask of the cores whose records clash with it.

The policy is eager and favours the requester's opponents. If the requesting core has an open transaction and a conflict is found, that transaction is dropped and its records are emptied. An external abort input has the same effect. Each core has an abort counter. Once a transaction has failed a set number of times, or once its line records would need more entries than the table holds, the core is told to take its non-transactional fallback path. Commit closes a transaction and resets the core's counter and fallback request. The caches, data rollback, register checkpoints and any arbitration policy live outside this block.

Top module: `txn_conflict_tracker`

## Requirements
- R1: Tracking is per line address. Any number of reads and writes by a core to one line within a transaction occupy a single table entry.
- R2: A write to a line conflicts with every other core whose open transaction has read or written that line.
- R3: A read conflicts only with other cores whose open transaction has written the line. Reads shared by several cores never conflict.
- R4: `conf_valid` and `conf_mask` reflect the access presented in the same cycle. `conf_core` equals the requesting core. The requester's own bit is never set in the mask.
- R5: When a conflicting access comes from a core with an open transaction, that transaction ends at the next clock edge and its records are emptied. The other cores' transactions are untouched.
- R6: An external abort of an open transaction ends it and empties its records. Later accesses by other cores to its former lines do not conflict.
- R7: Commit ends the transaction, empties its records, and clears the core's abort count and fallback request.
- R8: The 100th abort since the last commit raises `fallback_req` for that core (1 to 99 aborts leave it low). While `fallback_req` is high, begin is ignored.
- R9: When a core with an open transaction touches a new line while all table entries (default 8) are in use, `fallback_req` rises and the transaction ends at the next edge, with no retry. Touching a line already in the table does not trigger this.
- R10: Begin from a core whose transaction is already open has no effect. Its records are kept.
- R11: An access from a core without an open transaction is checked against the others and reported, but is never recorded and drops no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin | input | NUM_CORES | Per-core transaction start pulse |
| txn_commit | input | NUM_CORES | Per-core commit pulse |
| txn_abort | input | NUM_CORES | Per-core external abort pulse |
| acc_valid | input | 1 | Snooped access present |
| acc_core | input | CORE_W | Requesting core index |
| acc_line | input | LINE_W | Cache line address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| conf_valid | output | 1 | Conflict found for the current access |
| conf_core | output | CORE_W | Core that presented the conflicting access |
| conf_mask | output | NUM_CORES | Cores whose records clash with the access |
| txn_active | output | NUM_CORES | Per-core open-transaction flag |
| fallback_req | output | NUM_CORES | Per-core request to use the fallback path |

## Verification
The assertions check the following on every cycle:
- a conflicting transactional requester is gone one edge later (R5);
- the requester never appears in its own mask (R4);
- a cleared table is empty on the next edge;
- a full table stays full until cleared;
- a line matches at most one entry;
- a core with a raised fallback request has no open transaction;
- the abort count stays within its limit.

Only the directed scenarios can show the rest:
- the asymmetric read/write rules;
- that records vanish after abort and commit, seen through the absence of later conflicts;
- the exact abort count at which fallback rises;
- the capacity boundary at eight lines;
- that non-transactional and repeated-begin stimuli change nothing.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  // Per-entry status of a tracked line
  typedef struct packed {
    logic valid;
    logic rd;
    logic wr;
  } line_flags_t;

  localparam line_flags_t FLAGS_EMPTY = '{valid: 1'b0, rd: 1'b0, wr: 1'b0};

endpackage

// File: rtl/tcd_line_set.sv
module tcd_line_set
  import tcd_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rec,
  input  logic              rec_wr,
  input  logic [LINE_W-1:0] lk_line,
  output logic              hit_r,
  output logic              hit_w,
  output logic              own_hit,
  output logic              full
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  line_flags_t       flag_q [DEPTH];
  line_flags_t       flag_d [DEPTH];
  logic [LINE_W-1:0] tag_q  [DEPTH];

  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  valid_v;
  logic [IDX_W-1:0]  free_idx;
  logic              has_free;
  logic              tag_we;

  // Lookup
  always_comb begin
    hit_r = 1'b0;
    hit_w = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      valid_v[i] = flag_q[i].valid;
      match[i]   = flag_q[i].valid && (tag_q[i] == lk_line);
      hit_r      = hit_r | (match[i] & flag_q[i].rd);
      hit_w      = hit_w | (match[i] & flag_q[i].wr);
    end
    own_hit = |match;
  end

  // Lowest free slot
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!flag_q[i].valid) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
    full = !has_free;
  end

  assign tag_we = !clr && rec && !own_hit && has_free;

  // Next state of the status bits
  always_comb begin
    for (int i = 0; i < DEPTH; i++) flag_d[i] = flag_q[i];
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) flag_d[i] = FLAGS_EMPTY;
    end else if (rec) begin
      if (own_hit) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (match[i]) begin
            flag_d[i].rd = flag_q[i].rd | !rec_wr;
            flag_d[i].wr = flag_q[i].wr | rec_wr;
          end
        end
      end else if (has_free) begin
        flag_d[free_idx] = '{valid: 1'b1, rd: !rec_wr, wr: rec_wr};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flag_q[i] <= FLAGS_EMPTY;
    end else begin
      for (int i = 0; i < DEPTH; i++) flag_q[i] <= flag_d[i];
    end
  end

  // Tags carry no reset: qualified by the valid bit
  always_ff @(posedge clk) begin
    if (tag_we) tag_q[free_idx] <= lk_line;
  end

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_v == '0));

  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);

endmodule

// File: rtl/tcd_txn_ctrl.sv
module tcd_txn_ctrl #(
  parameter int RETRY_LIMIT = 100,
  parameter int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic begin_i,
  input  logic commit_i,
  input  logic abort_i,
  input  logic conf_kill_i,
  input  logic ovf_i,
  output logic active_o,
  output logic fallback_o,
  output logic clr_o
);

  logic             active_q, active_d;
  logic             fb_q, fb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kill;
  logic             ovf;
  logic             cnt_en;

  assign kill = active_q && (abort_i || conf_kill_i);
  assign ovf  = active_q && ovf_i && !kill;

  always_comb begin
    active_d = active_q;
    fb_d     = fb_q;
    cnt_d    = cnt_q;
    if (kill) begin
      active_d = 1'b0;
      if (cnt_q != CNT_W'(RETRY_LIMIT)) cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(RETRY_LIMIT - 1)) fb_d = 1'b1;
    end else if (ovf) begin
      active_d = 1'b0;
      fb_d     = 1'b1;
    end else if (commit_i) begin
      active_d = 1'b0;
      fb_d     = 1'b0;
      cnt_d    = '0;
    end else if (begin_i && !active_q && !fb_q) begin
      active_d = 1'b1;
    end
  end

  assign cnt_en = kill || commit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fb_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      fb_q     <= fb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o   = active_q;
  assign fallback_o = fb_q;
  assign clr_o      = commit_i || kill || ovf;

  p_fallback_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_q |-> !active_q);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RETRY_LIMIT));

  p_begin_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && begin_i && !abort_i && !conf_kill_i && !ovf_i && !commit_i) |=> active_q);

endmodule

// File: rtl/tcd_conflict_eval.sv
module tcd_conflict_eval #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                 acc_valid,
  input  logic [CORE_W-1:0]    acc_core,
  input  logic                 acc_write,
  input  logic [NUM_CORES-1:0] active,
  input  logic [NUM_CORES-1:0] hit_r,
  input  logic [NUM_CORES-1:0] hit_w,
  output logic [NUM_CORES-1:0] mask
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic other;
    assign other   = (acc_core != CORE_W'(c));
    assign mask[c] = acc_valid && other && active[c] &&
                     (hit_w[c] || (acc_write && hit_r[c]));
  end

endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int NUM_CORES   = 4,
  parameter int LINE_W      = 26,
  parameter int SET_DEPTH   = 8,
  parameter int RETRY_LIMIT = 100,
  parameter int CORE_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] txn_begin,
  input  logic [NUM_CORES-1:0] txn_commit,
  input  logic [NUM_CORES-1:0] txn_abort,
  input  logic                 acc_valid,
  input  logic [CORE_W-1:0]    acc_core,
  input  logic [LINE_W-1:0]    acc_line,
  input  logic                 acc_write,
  output logic                 conf_valid,
  output logic [CORE_W-1:0]    conf_core,
  output logic [NUM_CORES-1:0] conf_mask,
  output logic [NUM_CORES-1:0] txn_active,
  output logic [NUM_CORES-1:0] fallback_req
);

  localparam int CNT_W = $clog2(RETRY_LIMIT + 1);

  logic [NUM_CORES-1:0] hit_r, hit_w, own_hit, full;
  logic [NUM_CORES-1:0] sel, rec_req, ovf, kill_req, clr;

  tcd_conflict_eval #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_eval (
    .acc_valid (acc_valid),
    .acc_core  (acc_core),
    .acc_write (acc_write),
    .active    (txn_active),
    .hit_r     (hit_r),
    .hit_w     (hit_w),
    .mask      (conf_mask)
  );

  assign conf_valid = |conf_mask;
  assign conf_core  = acc_core;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign sel[c]      = acc_valid && (acc_core == CORE_W'(c));
    assign rec_req[c]  = sel[c] && txn_active[c] && !conf_valid;
    assign ovf[c]      = rec_req[c] && full[c] && !own_hit[c];
    assign kill_req[c] = sel[c] && conf_valid;

    tcd_line_set #(.LINE_W(LINE_W), .DEPTH(SET_DEPTH)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr[c]),
      .rec     (rec_req[c]),
      .rec_wr  (acc_write),
      .lk_line (acc_line),
      .hit_r   (hit_r[c]),
      .hit_w   (hit_w[c]),
      .own_hit (own_hit[c]),
      .full    (full[c])
    );

    tcd_txn_ctrl #(.RETRY_LIMIT(RETRY_LIMIT), .CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .begin_i     (txn_begin[c]),
      .commit_i    (txn_commit[c]),
      .abort_i     (txn_abort[c]),
      .conf_kill_i (kill_req[c]),
      .ovf_i       (ovf[c]),
      .active_o    (txn_active[c]),
      .fallback_o  (fallback_req[c]),
      .clr_o       (clr[c])
    );
  end

  p_requester_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && conf_valid && txn_active[acc_core]) |=> !txn_active[$past(acc_core)]);

  p_self_excluded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conf_valid |-> !conf_mask[conf_core]);

endmodule

// File: tb/txn_conflict_tracker_test.sv
module txn_conflict_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int CW    = 2;
  localparam int LW    = 26;
  localparam int DEPTH = 8;
  localparam int LIMIT = 100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  txn_begin, txn_commit, txn_abort;
  logic          acc_valid;
  logic [CW-1:0] acc_core;
  logic [LW-1:0] acc_line;
  logic          acc_write;
  logic          conf_valid;
  logic [CW-1:0] conf_core;
  logic [N-1:0]  conf_mask, txn_active, fallback_req;

  int checks = 0;
  int fails  = 0;

  txn_conflict_tracker #(.NUM_CORES(N), .LINE_W(LW), .SET_DEPTH(DEPTH),
                         .RETRY_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
    .txn_abort(txn_abort), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_line(acc_line), .acc_write(acc_write), .conf_valid(conf_valid),
    .conf_core(conf_core), .conf_mask(conf_mask), .txn_active(txn_active),
    .fallback_req(fallback_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; txn_begin = '0; txn_commit = '0; txn_abort = '0;
    acc_valid = 1'b0; acc_core = '0; acc_line = '0; acc_write = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tb_begin(input int c);
    @(negedge clk); txn_begin[c] = 1'b1;
    @(negedge clk); txn_begin[c] = 1'b0;
  endtask

  task automatic tb_commit(input int c);
    @(negedge clk); txn_commit[c] = 1'b1;
    @(negedge clk); txn_commit[c] = 1'b0;
  endtask

  task automatic tb_abort(input int c);
    @(negedge clk); txn_abort[c] = 1'b1;
    @(negedge clk); txn_abort[c] = 1'b0;
  endtask

  // Drive an access, check the same-cycle conflict outputs
  task automatic access(input int c, input int line, input bit wr,
                        input int exp_mask, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_core = CW'(c); acc_line = LW'(line); acc_write = wr;
    #1;
    chk(req, "conf_mask", int'(conf_mask), exp_mask);
    chk(req, "conf_valid", int'(conf_valid), (exp_mask != 0) ? 1 : 0);
    if (exp_mask != 0) chk(req, "conf_core", int'(conf_core), c);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R4", "idle conf_valid", int'(conf_valid), 0);
    chk("R7", "reset active", int'(txn_active), 0);
    chk("R8", "reset fallback", int'(fallback_req), 0);
  endtask

  task automatic t_write_rules();
    do_reset();
    tb_begin(0); tb_begin(1); tb_begin(2);
    access(0, 'h10, 1'b0, 0, "R2");
    access(0, 'h11, 1'b1, 0, "R2");
    access(1, 'h10, 1'b1, 'b0001, "R2");   // write vs other's read
    chk("R5", "requester dropped", int'(txn_active[1]), 0);
    chk("R5", "opponent kept", int'(txn_active[0]), 1);
    access(2, 'h11, 1'b1, 'b0001, "R2");   // write vs other's write
  endtask

  task automatic t_read_rules();
    do_reset();
    tb_begin(0); tb_begin(1); tb_begin(2);
    access(0, 'h20, 1'b0, 0, "R3");
    access(1, 'h20, 1'b0, 0, "R3");        // shared read
    access(0, 'h21, 1'b1, 0, "R3");
    access(2, 'h21, 1'b0, 'b0001, "R3");   // read vs other's write
    access(0, 'h20, 1'b1, 'b0010, "R3");   // upgrade clashes with core1 read
  endtask

  task automatic t_multi_mask();
    do_reset();
    tb_begin(0); tb_begin(1); tb_begin(2);
    access(0, 'h30, 1'b0, 0, "R4");
    access(1, 'h30, 1'b0, 0, "R4");
    access(0, 'h30, 1'b0, 0, "R4");        // own line: never self
    access(2, 'h30, 1'b1, 'b0011, "R4");
  endtask

  task automatic t_restart_clears();
    do_reset();
    tb_begin(0); tb_begin(1); tb_begin(3);
    access(0, 'h40, 1'b0, 0, "R5");
    access(1, 'h41, 1'b1, 0, "R5");
    access(1, 'h40, 1'b1, 'b0001, "R5");   // core1 dropped
    access(3, 'h41, 1'b1, 0, "R5");        // core1 set was emptied
    tb_begin(1);
    chk("R5", "restart active", int'(txn_active[1]), 1);
  endtask

  task automatic t_ext_abort();
    do_reset();
    tb_begin(2); tb_begin(1);
    access(2, 'h50, 1'b1, 0, "R6");
    tb_abort(2);
    chk("R6", "aborted active", int'(txn_active[2]), 0);
    access(1, 'h50, 1'b0, 0, "R6");
  endtask

  task automatic t_commit();
    do_reset();
    tb_begin(0); tb_begin(2);
    access(0, 'h60, 1'b1, 0, "R7");
    tb_commit(0);
    chk("R7", "committed active", int'(txn_active[0]), 0);
    access(2, 'h60, 1'b1, 0, "R7");
  endtask

  task automatic t_retry_limit();
    do_reset();
    for (int i = 0; i < LIMIT - 1; i++) begin
      tb_begin(3); tb_abort(3);
    end
    chk("R8", "fallback after 99", int'(fallback_req[3]), 0);
    tb_begin(3);
    chk("R8", "active before 100th", int'(txn_active[3]), 1);
    tb_abort(3);
    chk("R8", "fallback after 100", int'(fallback_req[3]), 1);
    tb_begin(3);
    chk("R8", "begin ignored in fallback", int'(txn_active[3]), 0);
    tb_commit(3);
    chk("R7", "commit clears fallback", int'(fallback_req[3]), 0);
    tb_begin(3); tb_abort(3);
    chk("R7", "count restarted", int'(fallback_req[3]), 0);
  endtask

  task automatic t_capacity();
    do_reset();
    tb_begin(2);
    for (int i = 0; i < DEPTH; i++) access(2, 'h100 + i, 1'b1, 0, "R9");
    access(2, 'h103, 1'b0, 0, "R1");
    chk("R1", "reuse keeps active", int'(txn_active[2]), 1);
    chk("R1", "reuse no fallback", int'(fallback_req[2]), 0);
    access(2, 'h100 + DEPTH, 1'b0, 0, "R9");
    chk("R9", "overflow fallback", int'(fallback_req[2]), 1);
    chk("R9", "overflow drops txn", int'(txn_active[2]), 0);
    tb_commit(2);
    chk("R7", "commit clears overflow", int'(fallback_req[2]), 0);
  endtask

  task automatic t_double_begin();
    do_reset();
    tb_begin(0); tb_begin(2);
    access(0, 'h70, 1'b0, 0, "R10");
    tb_begin(0);
    chk("R10", "still active", int'(txn_active[0]), 1);
    access(2, 'h70, 1'b1, 'b0001, "R10");  // record survived
  endtask

  task automatic t_non_txn();
    do_reset();
    tb_begin(0);
    access(0, 'h80, 1'b1, 0, "R11");
    access(3, 'h80, 1'b0, 'b0001, "R11");  // checked and reported
    chk("R11", "owner kept", int'(txn_active[0]), 1);
    access(3, 'h81, 1'b1, 0, "R11");
    access(0, 'h81, 1'b1, 0, "R11");       // not recorded
    chk("R11", "requester inactive", int'(txn_active[3]), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_write_rules();
    t_read_rules();
    t_multi_mask();
    t_restart_clears();
    t_ext_abort();
    t_commit();
    t_retry_limit();
    t_capacity();
    t_double_begin();
    t_non_txn();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule